// File: doc/BRIEF.md
# Per-Warp Texture Scheduling Hash

This block holds an 8-bit scheduling tag for every warp. Each tag has two fields: a 5-bit phase count in the upper bits and a 3-bit texture count in the lower bits. When a texture instruction issues, the block shows the issuing warp's tag on its output in that same cycle. It then changes the stored tag at the next clock edge, using the instruction's 2-bit step code. The update is postfix: the instruction uses the value the tag held before the change.

A texture step adds one to the texture count. A phase step adds one to the phase count and sets the texture count to zero. The no-step code and the reserved code leave the tag as it is. Each warp's tag is separate from the others, so issues from different warps can arrive on back-to-back cycles. Reset sets every tag to zero.

Top module: `tex_sched_hash`

## Requirements
- R1: While reset is asserted and after it is released, every warp's tag reads as 0 until that warp's first update.
- R2: `hash_o` always equals the stored tag of the warp selected by `warp_i`, with no register in the path. During an issue it therefore shows the value from before the update.
- R3: The tag layout is {phase[4:0], tex[2:0]}. The phase field is `hash_o[7:3]` and the texture field is `hash_o[2:0]`.
- R4: An issue with `ctrl_i` = 2'b01 adds one to the selected warp's texture field at the next clock edge and leaves its phase field unchanged.
- R5: An issue with `ctrl_i` = 2'b10 adds one to the selected warp's phase field at the next clock edge and sets its texture field to 0.
- R6: An issue with `ctrl_i` = 2'b00, or with the reserved code 2'b11, leaves the selected warp's tag unchanged.
- R7: When `issue_i` is low, no tag changes, whatever the values of `warp_i` and `ctrl_i`.
- R8: An issue changes only the addressed warp's tag. Issues from different warps on consecutive cycles each update their own warp.
- R9: Both fields wrap at their width: texture 7 steps to 0, and phase 31 steps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | A texture instruction issues this cycle |
| warp_i | input | 3 | Warp being read and, on an issue, updated |
| ctrl_i | input | 2 | Step code: 00 none, 01 texture, 10 phase, 11 reserved (treated as none) |
| hash_o | output | 8 | Current tag of warp `warp_i` |

## Verification
The assertions check on every cycle that:
- the output matches the addressed tag;
- each step code changes the tag as required;
- a cycle with no issue changes nothing;
- every warp that is not addressed keeps its value.

Only the bench scenarios show:
- the values that accumulate over many issues, through long chains of random steps on interleaved warps;
- both fields wrapping around;
- a phase step clearing a non-zero texture count;
- a mid-run reset returning all warps to zero.

// File: rtl/hsh_pkg.sv
package hsh_pkg;
  typedef enum logic [1:0] {
    HOP_NONE  = 2'b00,
    HOP_TEX   = 2'b01,
    HOP_PHASE = 2'b10,
    HOP_RSVD  = 2'b11
  } hsh_op_e;
endpackage

// File: rtl/hsh_decode.sv
module hsh_decode
  import hsh_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic                 issue_i,
  input  logic [WID_W-1:0]     warp_i,
  input  logic [1:0]           ctrl_i,
  output logic [NUM_WARPS-1:0] slot_we,
  output logic                 bump_tex,
  output logic                 bump_phase
);
  hsh_op_e op;

  always_comb begin
    op = hsh_op_e'(ctrl_i);
    bump_tex   = (op == HOP_TEX);
    bump_phase = (op == HOP_PHASE);
  end

  for (genvar k = 0; k < NUM_WARPS; k++) begin : g_we
    assign slot_we[k] = issue_i && (warp_i == WID_W'(k));
  end
endmodule

// File: rtl/hsh_slot.sv
module hsh_slot #(
  parameter int PHASE_W = 5,
  parameter int TEX_W   = 3,
  localparam int HASH_W = PHASE_W + TEX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              bump_tex,
  input  logic              bump_phase,
  output logic [HASH_W-1:0] hash_q
);
  function automatic logic [HASH_W-1:0] step(input logic [HASH_W-1:0] h,
                                             input logic bt, input logic bp);
    logic [PHASE_W-1:0] ph;
    logic [TEX_W-1:0]   tx;
    ph = h[HASH_W-1:TEX_W];
    tx = h[TEX_W-1:0];
    if (bp) begin
      ph = ph + 1'b1;
      tx = '0;
    end else if (bt) begin
      tx = tx + 1'b1;
    end
    return {ph, tx};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)  hash_q <= '0;
    else if (we) hash_q <= step(hash_q, bump_tex, bump_phase);
  end
endmodule

// File: rtl/tex_sched_hash.sv
module tex_sched_hash #(
  parameter int NUM_WARPS = 8,
  parameter int PHASE_W   = 5,
  parameter int TEX_W     = 3,
  localparam int WID_W    = $clog2(NUM_WARPS),
  localparam int HASH_W   = PHASE_W + TEX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [WID_W-1:0]  warp_i,
  input  logic [1:0]        ctrl_i,
  output logic [HASH_W-1:0] hash_o
);
  // NUM_WARPS is expected to be a power of two so every warp_i code is a real warp.
  logic [NUM_WARPS-1:0]        slot_we;
  logic                        bump_tex;
  logic                        bump_phase;
  logic [HASH_W-1:0]           slot_hash [NUM_WARPS];
  logic [NUM_WARPS*HASH_W-1:0] state_flat;

  hsh_decode #(.NUM_WARPS(NUM_WARPS)) u_dec (
    .issue_i   (issue_i),
    .warp_i    (warp_i),
    .ctrl_i    (ctrl_i),
    .slot_we   (slot_we),
    .bump_tex  (bump_tex),
    .bump_phase(bump_phase)
  );

  for (genvar k = 0; k < NUM_WARPS; k++) begin : g_slot
    hsh_slot #(.PHASE_W(PHASE_W), .TEX_W(TEX_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (slot_we[k]),
      .bump_tex  (bump_tex),
      .bump_phase(bump_phase),
      .hash_q    (slot_hash[k])
    );
    assign state_flat[k*HASH_W +: HASH_W] = slot_hash[k];
  end

  assign hash_o = slot_hash[warp_i];
endmodule

// File: rtl/hsh_chk.sv
module hsh_chk #(
  parameter int NUM_WARPS = 8,
  parameter int PHASE_W   = 5,
  parameter int TEX_W     = 3,
  localparam int WID_W    = $clog2(NUM_WARPS),
  localparam int HASH_W   = PHASE_W + TEX_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        issue_i,
  input logic [WID_W-1:0]            warp_i,
  input logic [1:0]                  ctrl_i,
  input logic [HASH_W-1:0]           hash_o,
  input logic [NUM_WARPS*HASH_W-1:0] state_flat
);
  logic [HASH_W-1:0] slot_now [NUM_WARPS];
  for (genvar k = 0; k < NUM_WARPS; k++) begin : g_view
    assign slot_now[k] = state_flat[k*HASH_W +: HASH_W];
  end

  // R1: registers are zero on the first cycle after reset
  a_r1_reset_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> state_flat == '0);

  // R2: output tracks the addressed tag
  a_r2_out_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    hash_o == slot_now[warp_i]);

  // R4 / R3: texture step, phase untouched
  a_r4_tex_step: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && ctrl_i == 2'b01 |=>
      slot_now[$past(warp_i)] ==
        {$past(hash_o[HASH_W-1:TEX_W]), TEX_W'($past(hash_o[TEX_W-1:0]) + 1'b1)});

  // R5: phase step clears texture
  a_r5_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && ctrl_i == 2'b10 |=>
      slot_now[$past(warp_i)] ==
        {PHASE_W'($past(hash_o[HASH_W-1:TEX_W]) + 1'b1), {TEX_W{1'b0}}});

  // R6: none and reserved codes hold
  a_r6_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && (ctrl_i == 2'b00 || ctrl_i == 2'b11) |=> $stable(state_flat));

  // R7: no issue, no change
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(state_flat));

  // R8: other warps unaffected
  for (genvar k = 0; k < NUM_WARPS; k++) begin : g_iso
    a_r8_other_warp: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && warp_i != WID_W'(k) |=> $stable(slot_now[k]));
  end
endmodule

bind tex_sched_hash hsh_chk #(
  .NUM_WARPS(NUM_WARPS), .PHASE_W(PHASE_W), .TEX_W(TEX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue_i   (issue_i),
  .warp_i    (warp_i),
  .ctrl_i    (ctrl_i),
  .hash_o    (hash_o),
  .state_flat(state_flat)
);

// File: tb/tex_sched_hash_tb.sv
module tex_sched_hash_tb;
  localparam int NW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue_i = 1'b0;
  logic [2:0] warp_i = '0;
  logic [1:0] ctrl_i = '0;
  logic [7:0] hash_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [NW];

  always #10 clk = ~clk;

  tex_sched_hash u_dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i),
    .warp_i(warp_i), .ctrl_i(ctrl_i), .hash_o(hash_o)
  );

  // phase count is bits 7:3, texture count is bits 2:0
  function automatic logic [7:0] expect_next(input logic [7:0] h, input logic [1:0] c);
    int ph, tx;
    ph = int'(h) / 8;
    tx = int'(h) % 8;
    case (c)
      2'b01: tx = (tx + 1) % 8;
      2'b10: begin ph = (ph + 1) % 32; tx = 0; end
      default: ;
    endcase
    return 8'(ph * 8 + tx);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive, check pre-update output, then apply model at the edge
  task automatic cycle(input string req, input logic iss, input logic [2:0] w,
                       input logic [1:0] c);
    @(negedge clk);
    issue_i = iss; warp_i = w; ctrl_i = c;
    #1 check(req, hash_o, model[w]);
    @(posedge clk);
    if (iss) model[w] = expect_next(model[w], c);
  endtask

  task automatic scan_all(input string req);
    for (int w = 0; w < NW; w++) cycle(req, 1'b0, 3'(w), 2'b01);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; issue_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < NW; w++) model[w] = '0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    do_reset();
    scan_all("R1 reset state");

    // R4 texture steps, R9 texture wrap after 8 steps
    for (int i = 0; i < 9; i++) cycle("R4/R9 tex step", 1'b1, 3'd2, 2'b01);
    cycle("R3 layout tex field", 1'b0, 3'd2, 2'b00);
    check("R9 tex wrap", hash_o, 8'h01);

    // R5 phase step clears nonzero texture
    cycle("R5 phase clears tex", 1'b1, 3'd2, 2'b10);
    cycle("R5 phase result", 1'b0, 3'd2, 2'b00);
    check("R3 layout phase field", hash_o, 8'h08);

    // R9 phase wrap
    for (int i = 0; i < 31; i++) cycle("R9 phase step", 1'b1, 3'd5, 2'b10);
    cycle("R9 phase at 31", 1'b1, 3'd5, 2'b10);
    cycle("R9 phase wrapped", 1'b0, 3'd5, 2'b00);
    check("R9 phase wrap zero", hash_o, 8'h00);

    // R6 none and reserved codes
    cycle("R6 prep", 1'b1, 3'd1, 2'b01);
    cycle("R6 none code", 1'b1, 3'd1, 2'b00);
    cycle("R6 reserved code", 1'b1, 3'd1, 2'b11);
    cycle("R6 held", 1'b0, 3'd1, 2'b00);
    check("R6 value", hash_o, 8'h01);

    // R7 no issue with step codes present
    for (int i = 0; i < 4; i++) cycle("R7 idle ignored", 1'b0, 3'd3, 2'b10);
    check("R7 unchanged", hash_o, 8'h00);

    // R8 back-to-back different warps
    cycle("R8 w6", 1'b1, 3'd6, 2'b01);
    cycle("R8 w7", 1'b1, 3'd7, 2'b10);
    cycle("R8 w6 again", 1'b1, 3'd6, 2'b01);
    scan_all("R8 isolation");

    // R2 random mix
    for (int i = 0; i < 3000; i++)
      cycle("R2 random", 1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
            2'($urandom_range(0, 3)));
    scan_all("R8 random final");

    // R1 mid-run reset
    do_reset();
    scan_all("R1 mid-run reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule